// File: doc/BRIEF.md
# Two-Mode Page Table Walker

This block turns a 32-bit linear address into a 36-bit physical address. It walks three levels of tables held in memory: a top table of four entries, then a directory, then a leaf page table. Every entry is 64 bits wide. Bit 0 of an entry is its present flag. Bits 35:12 hold the 24-bit frame number. The other bits are flags or reserved, and the walker ignores them. One exception applies at the directory level: when large pages are allowed and bit 7 of the directory entry is set, the walk stops there and maps a 2 MB page.

A translation request carries four things:
- the linear address;
- a base register value, whose bits 31:5 give the 32-byte-aligned address of the top table;
- a translation-enable flag;
- a large-page-enable flag.

The walker reads entries over a simple memory port. It issues a read as a one-cycle pulse and waits for a single response, so at most one read is in flight. It ends each walk with a one-cycle done pulse. That pulse carries either the physical address or a not-present fault, together with the level that failed. When translation is off, the linear address passes straight through and no memory is read.

Top module: `xlat_walker`

## Requirements
- R1: After reset, req_ready is 1, while done, fault and mem_rd_valid are 0 and phys_addr is 0.
- R2: With req_xlat_en low, an accepted request gives done in the next cycle. phys_addr then equals the linear address zero-extended to 36 bits, fault is 0, and no memory read is issued.
- R3: The first read of a walk goes to ({req_base[31:5], 5'b0} + 8 * lin[31:30]). The physical address is 36 bits wide with the upper four bits zero.
- R4: The second read goes to ({top_entry[35:12], 12'b0} + 8 * lin[29:21]).
- R5: For a 4 KB page, the third read goes to ({dir_entry[35:12], 12'b0} + 8 * lin[20:12]).
- R6: A completed 4 KB walk returns phys_addr = {leaf_entry[35:12], lin[11:0]}. Entry bits 63:36 and the flag bits 11:1 have no effect on the result.
- R7: When req_big_en is 1 and bit 7 of the directory entry is set, the walk ends after two reads. It returns phys_addr = {dir_entry[35:21], lin[20:0]}, and directory bits 20:12 are ignored.
- R8: When req_big_en is 0, directory bit 7 has no effect: the walk makes its third read and returns a 4 KB result.
- R9: When an entry has bit 0 clear, the walk stops with fault = 1 and fault_level set to 0 (top table), 1 (directory) or 2 (leaf table). No further read follows.
- R10: mem_rd_valid is a one-cycle pulse, and no new read is issued while a response is still pending.
- R11: done lasts exactly one cycle. A request is accepted only while req_ready is 1, and a req_valid raised during a walk does not change that walk's reads or result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | High when idle and able to accept a request |
| req_lin | input | 32 | Linear address to translate |
| req_base | input | 32 | Base register value; bits 31:5 locate the top table |
| req_xlat_en | input | 1 | Translation enable; when low, the address passes through |
| req_big_en | input | 1 | Permits 2 MB pages at the directory level |
| mem_rd_valid | output | 1 | One-cycle entry read request |
| mem_rd_addr | output | 36 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 64 | Entry returned by memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Set together with done when an entry was not present |
| fault_level | output | 2 | Level of the failing entry: 0, 1 or 2 |
| phys_addr | output | 36 | Translated physical address, valid with done |

## Verification
The assertions assume that memory returns exactly one mem_rsp_valid for each mem_rd_valid, after at least one cycle. They also assume that no response arrives when no read is pending. They assume that the request inputs are held only for the single accepting cycle, because they latch the linear address at acceptance. The bench memory model meets all of this: it takes one read at a time and answers it after a fixed two-cycle latency. Entries the bench never wrote are returned as zero. The bench raises req_valid for exactly one cycle, except in the one scenario that deliberately pulses it during a busy walk.

// File: rtl/xw_pkg.sv
package xw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TOP_RD,
      ST_DIR_RD,
      ST_LEAF_RD,
      ST_DONE,
      ST_FAULT
   } walk_state_t;

   typedef enum logic [1:0] {
      LVL_TOP  = 2'd0,
      LVL_DIR  = 2'd1,
      LVL_LEAF = 2'd2
   } walk_level_t;

endpackage

// File: rtl/xw_entry_dec.sv
module xw_entry_dec #(
   parameter int ENTRY_W     = 64,
   parameter int PHYS_W      = 36,
   parameter int OFF_W       = 12,
   parameter int SIZE_BIT    = 7,
   parameter bit LARGE_PAGES = 1'b1,
   localparam int FRAME_W    = PHYS_W - OFF_W
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic               big_allowed,
   output logic               present,
   output logic               take_big,
   output logic [FRAME_W-1:0] frame
);

   assign present = entry[0];
   assign frame   = entry[PHYS_W-1:OFF_W];

   generate
      if (LARGE_PAGES) begin : g_big
         assign take_big = big_allowed & entry[SIZE_BIT];
      end else begin : g_small
         assign take_big = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/xw_addr_calc.sv
module xw_addr_calc #(
   parameter int LIN_W      = 32,
   parameter int PHYS_W     = 36,
   parameter int OFF_W      = 12,
   parameter int IDX_W      = 9,
   parameter int TOP_W      = 2,
   parameter int ALIGN_W    = 5,
   parameter int ENTRY_W    = 64,
   localparam int FRAME_W   = PHYS_W - OFF_W,
   localparam int ENT_SHIFT = $clog2(ENTRY_W / 8)
) (
   input  logic [LIN_W-1:0]   new_lin,
   input  logic [LIN_W-1:0]   new_base,
   input  logic [LIN_W-1:0]   held_lin,
   input  logic [FRAME_W-1:0] entry_frame,
   output logic [PHYS_W-1:0]  top_addr,
   output logic [PHYS_W-1:0]  dir_addr,
   output logic [PHYS_W-1:0]  leaf_addr
);

   logic [TOP_W-1:0]  top_idx;
   logic [IDX_W-1:0]  dir_idx;
   logic [IDX_W-1:0]  leaf_idx;
   logic [PHYS_W-1:0] top_base;
   logic [PHYS_W-1:0] frame_base;

   assign top_idx  = new_lin[LIN_W-1 -: TOP_W];
   assign dir_idx  = held_lin[LIN_W-TOP_W-1 -: IDX_W];
   assign leaf_idx = held_lin[OFF_W +: IDX_W];

   assign top_base   = PHYS_W'({new_base[LIN_W-1:ALIGN_W], {ALIGN_W{1'b0}}});
   assign frame_base = {entry_frame, {OFF_W{1'b0}}};

   assign top_addr  = top_base   + PHYS_W'({top_idx,  {ENT_SHIFT{1'b0}}});
   assign dir_addr  = frame_base + PHYS_W'({dir_idx,  {ENT_SHIFT{1'b0}}});
   assign leaf_addr = frame_base + PHYS_W'({leaf_idx, {ENT_SHIFT{1'b0}}});

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import xw_pkg::*;
#(
   parameter int LIN_W       = 32,
   parameter int PHYS_W      = 36,
   parameter int ENTRY_W     = 64,
   parameter int OFF_W       = 12,
   parameter int IDX_W       = 9,
   parameter int TOP_W       = 2,
   parameter int ALIGN_W     = 5,
   parameter int SIZE_BIT    = 7,
   parameter bit LARGE_PAGES = 1'b1,
   localparam int FRAME_W    = PHYS_W - OFF_W,
   localparam int BIG_OFF_W  = OFF_W + IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [LIN_W-1:0]   req_lin,
   input  logic [LIN_W-1:0]   req_base,
   input  logic               req_xlat_en,
   input  logic               req_big_en,
   output logic               mem_rd_valid,
   output logic [PHYS_W-1:0]  mem_rd_addr,
   input  logic               mem_rsp_valid,
   input  logic [ENTRY_W-1:0] mem_rsp_data,
   output logic               done,
   output logic               fault,
   output logic [1:0]         fault_level,
   output logic [PHYS_W-1:0]  phys_addr
);

   initial begin
      assert (LIN_W == TOP_W + 2 * IDX_W + OFF_W)
         else $error("linear width must equal the sum of the index and offset fields");
      assert (PHYS_W > LIN_W && PHYS_W <= ENTRY_W)
         else $error("physical width must exceed linear width and fit in an entry");
      assert ((ENTRY_W / 8) << IDX_W == (1 << OFF_W))
         else $error("one table must fill exactly one small page");
      assert (SIZE_BIT < OFF_W && SIZE_BIT > 0)
         else $error("page-size flag must lie in the flag field");
      assert ((1 << ALIGN_W) >= (ENTRY_W / 8) * (1 << TOP_W))
         else $error("top table alignment must cover its entries");
   end

   walk_state_t        state;
   logic [LIN_W-1:0]   lin_q;
   logic               big_q;
   logic               ent_present;
   logic               ent_big;
   logic [FRAME_W-1:0] ent_frame;
   logic [PHYS_W-1:0]  top_addr;
   logic [PHYS_W-1:0]  dir_addr;
   logic [PHYS_W-1:0]  leaf_addr;

   xw_entry_dec #(
      .ENTRY_W     (ENTRY_W),
      .PHYS_W      (PHYS_W),
      .OFF_W       (OFF_W),
      .SIZE_BIT    (SIZE_BIT),
      .LARGE_PAGES (LARGE_PAGES)
   ) u_dec (
      .entry       (mem_rsp_data),
      .big_allowed (big_q),
      .present     (ent_present),
      .take_big    (ent_big),
      .frame       (ent_frame)
   );

   xw_addr_calc #(
      .LIN_W   (LIN_W),
      .PHYS_W  (PHYS_W),
      .OFF_W   (OFF_W),
      .IDX_W   (IDX_W),
      .TOP_W   (TOP_W),
      .ALIGN_W (ALIGN_W),
      .ENTRY_W (ENTRY_W)
   ) u_addr (
      .new_lin     (req_lin),
      .new_base    (req_base),
      .held_lin    (lin_q),
      .entry_frame (ent_frame),
      .top_addr    (top_addr),
      .dir_addr    (dir_addr),
      .leaf_addr   (leaf_addr)
   );

   assign req_ready = (state == ST_IDLE);
   assign done      = (state == ST_DONE) || (state == ST_FAULT);
   assign fault     = (state == ST_FAULT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         lin_q        <= '0;
         big_q        <= 1'b0;
         mem_rd_valid <= 1'b0;
         mem_rd_addr  <= '0;
         phys_addr    <= '0;
         fault_level  <= '0;
      end else begin
         mem_rd_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  lin_q       <= req_lin;
                  big_q       <= req_big_en;
                  fault_level <= '0;
                  if (req_xlat_en) begin
                     state        <= ST_TOP_RD;
                     mem_rd_valid <= 1'b1;
                     mem_rd_addr  <= top_addr;
                  end else begin
                     state     <= ST_DONE;
                     phys_addr <= PHYS_W'(req_lin);
                  end
               end
            end
            ST_TOP_RD: begin
               if (mem_rsp_valid) begin
                  if (!ent_present) begin
                     state       <= ST_FAULT;
                     fault_level <= LVL_TOP;
                     phys_addr   <= '0;
                  end else begin
                     state        <= ST_DIR_RD;
                     mem_rd_valid <= 1'b1;
                     mem_rd_addr  <= dir_addr;
                  end
               end
            end
            ST_DIR_RD: begin
               if (mem_rsp_valid) begin
                  if (!ent_present) begin
                     state       <= ST_FAULT;
                     fault_level <= LVL_DIR;
                     phys_addr   <= '0;
                  end else if (ent_big) begin
                     state     <= ST_DONE;
                     phys_addr <= {mem_rsp_data[PHYS_W-1:BIG_OFF_W], lin_q[BIG_OFF_W-1:0]};
                  end else begin
                     state        <= ST_LEAF_RD;
                     mem_rd_valid <= 1'b1;
                     mem_rd_addr  <= leaf_addr;
                  end
               end
            end
            ST_LEAF_RD: begin
               if (mem_rsp_valid) begin
                  if (!ent_present) begin
                     state       <= ST_FAULT;
                     fault_level <= LVL_LEAF;
                     phys_addr   <= '0;
                  end else begin
                     state     <= ST_DONE;
                     phys_addr <= {ent_frame, lin_q[OFF_W-1:0]};
                  end
               end
            end
            ST_DONE, ST_FAULT: state <= ST_IDLE;
            default:           state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/xw_chk.sv
module xw_chk #(
   parameter int LIN_W  = 32,
   parameter int PHYS_W = 36,
   parameter int OFF_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [LIN_W-1:0]  req_lin,
   input logic              req_xlat_en,
   input logic              mem_rd_valid,
   input logic              mem_rsp_valid,
   input logic              done,
   input logic              fault,
   input logic [1:0]        fault_level,
   input logic [PHYS_W-1:0] phys_addr
);

   logic [LIN_W-1:0] acc_lin;
   logic             acc_en;
   logic [1:0]       pending;
   logic [2:0]       reads;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_lin <= '0;
         acc_en  <= 1'b0;
         pending <= '0;
         reads   <= '0;
      end else begin
         if (req_valid && req_ready) begin
            acc_lin <= req_lin;
            acc_en  <= req_xlat_en;
            reads   <= '0;
         end else if (mem_rd_valid) begin
            reads <= reads + 3'd1;
         end
         if (mem_rd_valid && !mem_rsp_valid) pending <= pending + 2'd1;
         else if (mem_rsp_valid && !mem_rd_valid && pending != 0) pending <= pending - 2'd1;
      end
   end

   // R10
   single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> pending == 2'd0);

   // R10
   read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |=> !mem_rd_valid);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> !req_ready);

   // R9
   fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (done && fault_level <= 2'd2));

   // R9
   fault_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> reads == 3'(fault_level) + 3'd1);

   // R6
   offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault) |-> phys_addr[OFF_W-1:0] == acc_lin[OFF_W-1:0]);

   // R2
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !acc_en) |-> (phys_addr == PHYS_W'(acc_lin) && !fault && reads == 3'd0));

endmodule

bind xlat_walker xw_chk #(
   .LIN_W  (LIN_W),
   .PHYS_W (PHYS_W),
   .OFF_W  (OFF_W)
) u_xw_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_lin       (req_lin),
   .req_xlat_en   (req_xlat_en),
   .mem_rd_valid  (mem_rd_valid),
   .mem_rsp_valid (mem_rsp_valid),
   .done          (done),
   .fault         (fault),
   .fault_level   (fault_level),
   .phys_addr     (phys_addr)
);

// File: tb/test_xlat_walker.sv
module test_xlat_walker;

   localparam int CLK_PERIOD = 10;
   localparam int MEM_LAT    = 2;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_lin = '0;
   logic [31:0] req_base = '0;
   logic        req_xlat_en = 1'b0;
   logic        req_big_en = 1'b0;
   logic        mem_rd_valid;
   logic [35:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        done;
   logic        fault;
   logic [1:0]  fault_level;
   logic [35:0] phys_addr;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   xlat_walker i_xlat_walker (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_lin       (req_lin),
      .req_base      (req_base),
      .req_xlat_en   (req_xlat_en),
      .req_big_en    (req_big_en),
      .mem_rd_valid  (mem_rd_valid),
      .mem_rd_addr   (mem_rd_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .done          (done),
      .fault         (fault),
      .fault_level   (fault_level),
      .phys_addr     (phys_addr)
   );

   // ---------------- memory model ----------------
   logic [63:0] mem [logic [35:0]];
   logic [35:0] rd_log [0:255];
   int          rd_cnt = 0;
   int          overlap = 0;
   logic        pend = 1'b0;
   logic [35:0] pend_addr = '0;
   int          pend_cnt = 0;

   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (mem_rd_valid) begin
         if (pend) overlap <= overlap + 1;
         pend      <= 1'b1;
         pend_addr <= mem_rd_addr;
         pend_cnt  <= MEM_LAT;
         rd_log[rd_cnt[7:0]] <= mem_rd_addr;
         rd_cnt    <= rd_cnt + 1;
      end else if (pend) begin
         if (pend_cnt == 1) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(pend_addr) ? mem[pend_addr] : 64'd0;
            pend          <= 1'b0;
         end
         pend_cnt <= pend_cnt - 1;
      end
   end

   // ---------------- watchdog ----------------
   int cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WATCHDOG) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, act=%0d exp<%0d cycles", cyc, WATCHDOG);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [35:0] top_a(input logic [31:0] base, input logic [31:0] lin);
      return {4'h0, base[31:5], 5'b0} + {31'd0, lin[31:30], 3'b0};
   endfunction

   function automatic logic [35:0] tab_a(input logic [23:0] frame, input logic [8:0] idx);
      return {frame, 12'h000} + {24'd0, idx, 3'b0};
   endfunction

   // entry with noise in bits 63:36 and flags 11:1 (bit 7 only when asked)
   function automatic logic [63:0] ent(input logic [23:0] frame, input bit pres, input bit big);
      return {28'hA5C_3E1, frame, 4'h0, big, 3'b110, 3'b011, pres};
   endfunction

   logic [35:0] r_phys;
   logic        r_fault;
   logic [1:0]  r_lvl;
   int          r_cyc;
   int          r_reads;
   int          r_first;

   task automatic run(input logic [31:0] lin, input logic [31:0] base,
                      input bit en, input bit big, input bit poke_busy);
      @(negedge clk);
      req_lin = lin; req_base = base; req_xlat_en = en; req_big_en = big;
      req_valid = 1'b1;
      r_first = rd_cnt;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      r_cyc = 1;
      while (!done && r_cyc < 200) begin
         if (poke_busy && r_cyc == 2) begin
            req_lin = 32'h0000_0FFF; req_xlat_en = 1'b0; req_valid = 1'b1;
         end else begin
            req_valid = 1'b0;
         end
         @(negedge clk);
         r_cyc = r_cyc + 1;
      end
      req_valid = 1'b0;
      r_phys = phys_addr; r_fault = fault; r_lvl = fault_level;
      r_reads = rd_cnt - r_first;
      @(negedge clk);
      chk(!done, "R11", "done one cycle", 64'(done), 64'd0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk(req_ready == 1'b1, "R1", "ready", 64'(req_ready), 64'd1);
      chk(done == 1'b0 && fault == 1'b0, "R1", "done/fault", {62'd0, done, fault}, 64'd0);
      chk(mem_rd_valid == 1'b0, "R1", "rd_valid", 64'(mem_rd_valid), 64'd0);
      chk(phys_addr == '0, "R1", "phys", 64'(phys_addr), 64'd0);
   endtask

   task automatic t_bypass(input logic [31:0] lin);
      run(lin, 32'h0000_1020, 1'b0, 1'b1, 1'b0);
      chk(r_cyc == 1, "R2", "latency", 64'(r_cyc), 64'd1);
      chk(r_phys == {4'h0, lin}, "R2", "phys", 64'(r_phys), {28'd0, 4'h0, lin});
      chk(r_reads == 0 && !r_fault, "R2", "reads/fault", 64'(r_reads), 64'd0);
   endtask

   task automatic t_walk4k(input logic [31:0] lin, input logic [31:0] base,
                           input logic [23:0] fd, input logic [23:0] fl, input logic [23:0] fp);
      logic [35:0] a0, a1, a2, exp;
      a0 = top_a(base, lin);
      a1 = tab_a(fd, lin[29:21]);
      a2 = tab_a(fl, lin[20:12]);
      mem[a0] = ent(fd, 1'b1, 1'b0);
      mem[a1] = ent(fl, 1'b1, 1'b0);
      mem[a2] = ent(fp, 1'b1, 1'b1);
      exp = {fp, lin[11:0]};
      run(lin, base, 1'b1, 1'b1, 1'b0);
      chk(r_reads == 3, "R5", "read count", 64'(r_reads), 64'd3);
      chk(rd_log[r_first[7:0]] == a0, "R3", "top addr", 64'(rd_log[r_first[7:0]]), 64'(a0));
      chk(rd_log[8'(r_first + 1)] == a1, "R4", "dir addr", 64'(rd_log[8'(r_first + 1)]), 64'(a1));
      chk(rd_log[8'(r_first + 2)] == a2, "R5", "leaf addr", 64'(rd_log[8'(r_first + 2)]), 64'(a2));
      chk(r_phys == exp && !r_fault, "R6", "phys 4K", 64'(r_phys), 64'(exp));
   endtask

   task automatic t_big(input logic [31:0] lin, input logic [31:0] base,
                        input logic [23:0] fd, input logic [23:0] fb, input logic [23:0] fp);
      logic [35:0] a0, a1, a2, exp;
      a0 = top_a(base, lin);
      a1 = tab_a(fd, lin[29:21]);
      a2 = tab_a(fb, lin[20:12]);
      mem[a0] = ent(fd, 1'b1, 1'b0);
      mem[a1] = ent(fb, 1'b1, 1'b1);
      mem[a2] = ent(fp, 1'b1, 1'b0);
      exp = {fb[23:9], lin[20:0]};
      run(lin, base, 1'b1, 1'b1, 1'b0);
      chk(r_reads == 2, "R7", "reads 2MB", 64'(r_reads), 64'd2);
      chk(r_phys == exp && !r_fault, "R7", "phys 2MB", 64'(r_phys), 64'(exp));
      // same tables with large pages off
      exp = {fp, lin[11:0]};
      run(lin, base, 1'b1, 1'b0, 1'b0);
      chk(r_reads == 3, "R8", "reads big off", 64'(r_reads), 64'd3);
      chk(rd_log[8'(r_first + 2)] == a2, "R8", "leaf addr", 64'(rd_log[8'(r_first + 2)]), 64'(a2));
      chk(r_phys == exp && !r_fault, "R8", "phys big off", 64'(r_phys), 64'(exp));
   endtask

   task automatic t_fault(input logic [1:0] lvl);
      logic [31:0] base, lin;
      logic [35:0] a0, a1, a2;
      logic [23:0] fd, fl;
      base = 32'h0000_2040;
      lin  = {lvl, 30'h0A5_5123} ^ {2'b00, 8'd0, lvl, 20'h0};
      fd   = 24'h90_0100 + 24'(lvl);
      fl   = 24'h91_0200 + 24'(lvl);
      a0 = top_a(base, lin);
      a1 = tab_a(fd, lin[29:21]);
      a2 = tab_a(fl, lin[20:12]);
      mem[a0] = ent(fd, lvl != 2'd0, 1'b0);
      mem[a1] = ent(fl, lvl != 2'd1, 1'b0);
      mem[a2] = ent(24'h12_3456, 1'b0, 1'b0);
      run(lin, base, 1'b1, 1'b1, 1'b0);
      chk(r_fault == 1'b1, "R9", "fault flag", 64'(r_fault), 64'd1);
      chk(r_lvl == lvl, "R9", "fault level", 64'(r_lvl), 64'(lvl));
      chk(r_reads == int'(lvl) + 1, "R9", "reads to fault", 64'(r_reads), 64'(int'(lvl) + 1));
   endtask

   task automatic t_busy();
      logic [31:0] lin;
      logic [35:0] exp;
      lin = 32'h6AB1_2C34;
      mem[top_a(32'h0000_3000, lin)] = ent(24'hB0_0001, 1'b1, 1'b0);
      mem[tab_a(24'hB0_0001, lin[29:21])] = ent(24'hB1_0002, 1'b1, 1'b0);
      mem[tab_a(24'hB1_0002, lin[20:12])] = ent(24'hCA_FE77, 1'b1, 1'b0);
      exp = {24'hCA_FE77, lin[11:0]};
      run(lin, 32'h0000_3000, 1'b1, 1'b0, 1'b1);
      chk(r_reads == 3, "R11", "busy reads", 64'(r_reads), 64'd3);
      chk(r_phys == exp, "R11", "busy phys", 64'(r_phys), 64'(exp));
      chk(req_ready == 1'b1, "R11", "ready after", 64'(req_ready), 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_bypass(32'hDEAD_BEEF);
      t_bypass(32'h0000_0001);
      t_walk4k(32'h8123_4567, 32'h0000_1020, 24'h12_3450, 24'hF0_0011, 24'hAB_CDEF);
      t_walk4k(32'hFFE0_1ABC, 32'h0000_1020, 24'h22_0001, 24'hE5_5550, 24'hFF_FFFF);
      t_big(32'h4055_4321, 32'h0000_1020, 24'h44_0000, 24'h77_71FF, 24'h33_3333);
      for (int l = 0; l < 3; l++) t_fault(2'(l));
      t_busy();
      chk(overlap == 0, "R10", "overlapping reads", 64'(overlap), 64'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule